// File: doc/BRIEF.md
# Unary and Widening-Multiply Group Unit

This unit executes the one-operand arithmetic group of a 32-bit register machine whose instructions name their operand with an addressing byte. That byte has a two-bit mode field in bits 7:6, a three-bit sub-operation field in bits 5:3 and a three-bit register field in bits 2:0. The unit runs bitwise complement, two's-complement negate with a most-negative-value guard, and an unsigned widening multiply of register 0 by a register operand. It also runs increment and decrement, either in the one-byte forms that carry the register number in the opcode or in the addressing-byte forms. Only register operands are handled. A memory mode, an unknown sub-operation or an unknown opcode raises a fault.

The surrounding pipeline reads the register that `rd_idx` names and presents its value on `opnd`. It presents register 0 on `acc`. Results come back as write pulses. The primary write port carries a result and its register index. A second port carries the high half of a product, which always goes to register 2. Separate enables say when the sign/zero flags and the overflow flag are to be updated.

The controller is a three-state machine. `S_IDLE` accepts an operation. Single-cycle operations and faults complete from `S_IDLE` and stay there. The transition `IDLE->MUL` happens when a multiply is accepted. `S_MUL` steps a shift-add multiplier once per cycle. The transition `MUL->WRITE` happens after the last step. `S_WRITE` emits both halves of the product. The transition `WRITE->IDLE` follows unconditionally.

Top module: `unary_grp_unit`

## Requirements
- R1: After reset, `busy`, `wr_en`, `hi_wr_en`, `sz_we`, `of_we` and `fault` are all 0.
- R2: Opcode 0xF7 with mode 3 and sub-operation 2 (complement) writes the bitwise inverse of `opnd` to register `modrm[2:0]`. It sets `sf` to bit 31 of the result and `zf` to (result == 0), clears `of`, and raises `sz_we` and `of_we`. The results appear one cycle after acceptance.
- R3: Opcode 0xF7 with mode 3 and sub-operation 3 (negate) on any value other than 0x80000000 writes 0 minus `opnd`. Flags are set as in R2, with `of` = 0.
- R4: Negate of 0x80000000 writes no register (`wr_en` = 0), and sets `sf` = 1, `zf` = 0 and `of` = 1 with `sz_we` and `of_we` raised.
- R5: Opcode 0xF7 with mode 3 and sub-operation 4 forms the unsigned 64-bit product of `acc` and `opnd`. The low half goes to register 0 on `wr_en`/`wr_data` and the high half goes on `hi_wr_en`/`hi_wr_data`. `of` is 1 exactly when the high half is nonzero, `of_we` = 1 and `sz_we` = 0. Both writes appear in the same cycle, XLEN+1 cycles after acceptance.
- R6: `busy` is 1 from the cycle after a multiply is accepted until the cycle its results appear. Any `op_valid` while busy is ignored and produces no write or fault.
- R7: Opcodes 0x40–0x47 increment, and 0x48–0x4F decrement, register `opcode[2:0]` with 32-bit wraparound. Flags are not written.
- R8: Opcode 0xFF with mode 3 increments register `modrm[2:0]` for sub-operation 0 and decrements it for sub-operation 1, with 32-bit wraparound. Flags are not written.
- R9: `fault` pulses one cycle after acceptance, with no register or flag write, in three cases. The first is a sub-operation other than 2, 3 or 4 under 0xF7, or other than 0 or 1 under 0xFF. The second is a mode other than 3 under either opcode. The third is any other opcode.
- R10: `rd_idx` combinationally equals `opcode[2:0]` for opcodes 0x40–0x4F and `modrm[2:0]` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| opcode | input | 8 | Primary opcode byte |
| modrm | input | 8 | Addressing byte (mode, sub-operation, register) |
| opnd | input | XLEN | Value of the register named by `rd_idx` |
| acc | input | XLEN | Value of register 0 |
| rd_idx | output | 3 | Register to be read onto `opnd` |
| busy | output | 1 | Multiply in progress |
| wr_en | output | 1 | Primary register write pulse |
| wr_idx | output | 3 | Primary write register index |
| wr_data | output | XLEN | Primary write data |
| hi_wr_en | output | 1 | Product high-half write pulse, to register 2 |
| hi_wr_data | output | XLEN | Product high half |
| sz_we | output | 1 | Update the sign and zero flags |
| of_we | output | 1 | Update the overflow flag |
| sf | output | 1 | Sign flag value |
| zf | output | 1 | Zero flag value |
| of | output | 1 | Overflow flag value |
| fault | output | 1 | Unsupported operation pulse |

## Verification
Complement, negate, increment, decrement and fault results are registered once, so they are due in the cycle after the accepting edge. Each task drives an operation on a falling edge and checks the outputs on the next falling edge. A multiply is due XLEN+1 cycles after acceptance. Its task checks on every falling edge in between that `busy` is held and that nothing is written, including after an extra operation is driven during that window. It then checks both halves of the product on exactly the following falling edge. `rd_idx` is combinational and is checked shortly after the inputs change.

// File: rtl/unary_grp_pkg.sv
package unary_grp_pkg;
    typedef enum logic [2:0] {
        K_NOT,
        K_NEG,
        K_MUL,
        K_INC,
        K_DEC,
        K_BAD
    } kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_MUL,
        S_WRITE
    } state_e;
endpackage

// File: rtl/unary_grp_decode.sv
module unary_grp_decode
    import unary_grp_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic [7:0] modrm,
    output kind_e      kind,
    output logic [2:0] rd_idx
);
    logic       reg_mode;
    logic [2:0] sub;

    assign reg_mode = (modrm[7:6] == 2'b11);
    assign sub      = modrm[5:3];

    always_comb begin
        kind   = K_BAD;
        rd_idx = modrm[2:0];
        if (opcode[7:4] == 4'h4) begin
            rd_idx = opcode[2:0];
            kind   = opcode[3] ? K_DEC : K_INC;
        end else if (opcode == 8'hF7 && reg_mode) begin
            case (sub)
                3'd2:    kind = K_NOT;
                3'd3:    kind = K_NEG;
                3'd4:    kind = K_MUL;
                default: kind = K_BAD;
            endcase
        end else if (opcode == 8'hFF && reg_mode) begin
            case (sub)
                3'd0:    kind = K_INC;
                3'd1:    kind = K_DEC;
                default: kind = K_BAD;
            endcase
        end
    end
endmodule

// File: rtl/unary_grp_alu.sv
module unary_grp_alu
    import unary_grp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  kind_e            kind,
    input  logic [XLEN-1:0]  opnd,
    output logic [XLEN-1:0]  res,
    output logic             res_we,
    output logic             flags_we,
    output logic             sf,
    output logic             zf,
    output logic             of
);
    localparam logic [XLEN-1:0] NEG_MIN = {1'b1, {(XLEN-1){1'b0}}};
    localparam logic [XLEN-1:0] ONE     = {{(XLEN-1){1'b0}}, 1'b1};

    logic neg_min;
    assign neg_min = (opnd == NEG_MIN);

    always_comb begin
        res      = opnd;
        res_we   = 1'b0;
        flags_we = 1'b0;
        case (kind)
            K_NOT: begin res = ~opnd;        res_we = 1'b1; flags_we = 1'b1; end
            K_NEG: begin res = '0 - opnd;    res_we = !neg_min; flags_we = 1'b1; end
            K_INC: begin res = opnd + ONE;   res_we = 1'b1; end
            K_DEC: begin res = opnd - ONE;   res_we = 1'b1; end
            default: ;
        endcase
        sf = res[XLEN-1];
        zf = (res == '0);
        of = 1'b0;
        if (kind == K_NEG && neg_min) begin
            sf = 1'b1;
            zf = 1'b0;
            of = 1'b1;
        end
    end
endmodule

// File: rtl/unary_grp_umul.sv
module unary_grp_umul #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    input  logic [XLEN-1:0] a_in,
    input  logic [XLEN-1:0] b_in,
    output logic [XLEN-1:0] prod_hi,
    output logic [XLEN-1:0] prod_lo
);
    logic [XLEN-1:0] mcand;
    logic [XLEN:0]   sum;

    assign sum = {1'b0, prod_hi} + (prod_lo[0] ? {1'b0, mcand} : '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand   <= '0;
            prod_hi <= '0;
            prod_lo <= '0;
        end else if (load) begin
            mcand   <= a_in;
            prod_hi <= '0;
            prod_lo <= b_in;
        end else if (step) begin
            prod_hi <= sum[XLEN:1];
            prod_lo <= {sum[0], prod_lo[XLEN-1:1]};
        end
    end
endmodule

// File: rtl/unary_grp_unit.sv
module unary_grp_unit
    import unary_grp_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [7:0]      opcode,
    input  logic [7:0]      modrm,
    input  logic [XLEN-1:0] opnd,
    input  logic [XLEN-1:0] acc,
    output logic [2:0]      rd_idx,
    output logic            busy,
    output logic            wr_en,
    output logic [2:0]      wr_idx,
    output logic [XLEN-1:0] wr_data,
    output logic            hi_wr_en,
    output logic [XLEN-1:0] hi_wr_data,
    output logic            sz_we,
    output logic            of_we,
    output logic            sf,
    output logic            zf,
    output logic            of,
    output logic            fault
);
    localparam int              CW       = $clog2(XLEN);
    localparam logic [CW-1:0]   LAST     = CW'(XLEN - 1);
    localparam logic [XLEN-1:0] NEG_MIN  = {1'b1, {(XLEN-1){1'b0}}};

    state_e          state, state_nx;
    kind_e           kind;
    logic [CW-1:0]   cnt;
    logic            accept;
    logic [XLEN-1:0] alu_res, prod_hi, prod_lo;
    logic            alu_we, alu_fwe, alu_sf, alu_zf, alu_of;

    unary_grp_decode u_dec (.opcode(opcode), .modrm(modrm), .kind(kind), .rd_idx(rd_idx));

    unary_grp_alu #(.XLEN(XLEN)) u_alu (
        .kind(kind), .opnd(opnd), .res(alu_res), .res_we(alu_we),
        .flags_we(alu_fwe), .sf(alu_sf), .zf(alu_zf), .of(alu_of)
    );

    unary_grp_umul #(.XLEN(XLEN)) u_mul (
        .clk(clk), .rst_n(rst_n),
        .load(accept && kind == K_MUL), .step(state == S_MUL),
        .a_in(acc), .b_in(opnd), .prod_hi(prod_hi), .prod_lo(prod_lo)
    );

    assign accept = op_valid && (state == S_IDLE);
    assign busy   = (state != S_IDLE);

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (accept && kind == K_MUL) state_nx = S_MUL;
            S_MUL:   if (cnt == LAST) state_nx = S_WRITE;
            S_WRITE: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0; wr_en <= 1'b0; wr_idx <= '0; wr_data <= '0;
            hi_wr_en <= 1'b0; hi_wr_data <= '0; sz_we <= 1'b0; of_we <= 1'b0;
            sf <= 1'b0; zf <= 1'b0; of <= 1'b0; fault <= 1'b0;
        end else begin
            wr_en <= 1'b0; hi_wr_en <= 1'b0; sz_we <= 1'b0; of_we <= 1'b0; fault <= 1'b0;
            unique case (state)
                S_IDLE: if (accept) begin
                    if (kind == K_BAD) begin
                        fault <= 1'b1;
                    end else if (kind == K_MUL) begin
                        cnt <= '0;
                    end else begin
                        wr_en   <= alu_we;
                        wr_idx  <= rd_idx;
                        wr_data <= alu_res;
                        if (alu_fwe) begin
                            sz_we <= 1'b1; of_we <= 1'b1;
                            sf <= alu_sf; zf <= alu_zf; of <= alu_of;
                        end
                    end
                end
                S_MUL: cnt <= cnt + 1'b1;
                S_WRITE: begin
                    wr_en      <= 1'b1;
                    wr_idx     <= 3'd0;
                    wr_data    <= prod_lo;
                    hi_wr_en   <= 1'b1;
                    hi_wr_data <= prod_hi;
                    of_we      <= 1'b1;
                    of         <= |prod_hi;
                end
            endcase
        end
    end

    // R4
    neg_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && kind == K_NEG && opnd == NEG_MIN |=> !wr_en && sz_we && sf && !zf && of);
    // R5
    hi_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr_en |-> (of == (hi_wr_data != '0)) && wr_en && wr_idx == 3'd0 && !sz_we);
    // R6
    mul_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && kind == K_MUL |=> busy && !wr_en && !fault);
    // R6
    hi_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_wr_en |-> $past(busy) && !busy);
    // R7
    incdec_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept && (kind == K_INC || kind == K_DEC) |=> wr_en && !sz_we && !of_we);
    // R9
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !wr_en && !hi_wr_en && !sz_we && !of_we);
endmodule

// File: tb/unary_grp_unit_test.sv
module unary_grp_unit_test;
    localparam int XLEN = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_valid = 1'b0;
    logic [7:0] opcode = '0, modrm = '0;
    logic [XLEN-1:0] opnd = '0, acc = '0;
    logic [2:0] rd_idx, wr_idx;
    logic busy, wr_en, hi_wr_en, sz_we, of_we, sf, zf, of, fault;
    logic [XLEN-1:0] wr_data, hi_wr_data;

    int total = 0;
    int failed = 0;

    always #5 clk = ~clk;

    unary_grp_unit #(.XLEN(XLEN)) uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode), .modrm(modrm),
        .opnd(opnd), .acc(acc), .rd_idx(rd_idx), .busy(busy), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_data(wr_data), .hi_wr_en(hi_wr_en), .hi_wr_data(hi_wr_data),
        .sz_we(sz_we), .of_we(of_we), .sf(sf), .zf(zf), .of(of), .fault(fault)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input [7:0] op, input [7:0] mr, input [31:0] v, input [31:0] a);
        @(negedge clk);
        op_valid = 1'b1; opcode = op; modrm = mr; opnd = v; acc = a;
    endtask

    task automatic settle;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk(!busy && !wr_en && !hi_wr_en && !sz_we && !of_we && !fault, "R1 reset",
            {busy, wr_en, hi_wr_en, sz_we, of_we, fault}, 0);
    endtask

    task automatic t_not(input [31:0] v, input [2:0] rm);
        logic [31:0] e;
        e = ~v;
        drive(8'hF7, {5'b11010, rm}, v, 0);
        #1 chk(rd_idx == rm, "R10 rd_idx modrm", rd_idx, rm);
        settle();
        chk(wr_en && wr_idx == rm && wr_data == e, "R2 not data", wr_data, e);
        chk(sz_we && of_we && sf == e[31] && zf == (e == 0) && !of, "R2 not flags",
            {sz_we, of_we, sf, zf, of}, {1'b1, 1'b1, e[31], e == 0, 1'b0});
    endtask

    task automatic t_neg(input [31:0] v);
        logic [31:0] e;
        e = 32'd0 - v;
        drive(8'hF7, 8'hDB, v, 0);
        settle();
        if (v == 32'h8000_0000) begin
            chk(!wr_en, "R4 neg min no write", wr_en, 0);
            chk(sz_we && of_we && sf && !zf && of, "R4 neg min flags", {sf, zf, of}, 3'b101);
        end else begin
            chk(wr_en && wr_idx == 3 && wr_data == e, "R3 neg data", wr_data, e);
            chk(sz_we && sf == e[31] && zf == (e == 0) && !of, "R3 neg flags",
                {sf, zf, of}, {e[31], e == 0, 1'b0});
        end
    endtask

    task automatic t_mul(input [31:0] a, input [31:0] b);
        logic [63:0] p;
        bit ok;
        p = {32'd0, a} * {32'd0, b};
        ok = 1'b1;
        drive(8'hF7, 8'hE1, b, a);
        @(negedge clk);
        chk(busy && !wr_en, "R6 busy after accept", busy, 1);
        opcode = 8'hF7; modrm = 8'hD3; opnd = 32'h1234;
        for (int i = 1; i <= XLEN; i++) begin
            @(negedge clk);
            op_valid = 1'b0;
            if (!busy || wr_en || hi_wr_en || fault) ok = 1'b0;
        end
        chk(ok, "R6 busy held, valid ignored", ok, 1);
        @(negedge clk);
        chk(wr_en && wr_idx == 0 && wr_data == p[31:0], "R5 mul low", wr_data, p[31:0]);
        chk(hi_wr_en && hi_wr_data == p[63:32], "R5 mul high", hi_wr_data, p[63:32]);
        chk(of_we && !sz_we && of == (p[63:32] != 0), "R5 mul of", of, p[63:32] != 0);
        chk(!busy, "R6 busy drops with write", busy, 0);
    endtask

    task automatic t_short(input [7:0] op, input [31:0] v);
        logic [31:0] e;
        e = op[3] ? v - 1 : v + 1;
        drive(op, 8'hC5, v, 0);
        #1 chk(rd_idx == op[2:0], "R10 rd_idx opcode", rd_idx, op[2:0]);
        settle();
        chk(wr_en && wr_idx == op[2:0] && wr_data == e && !sz_we && !of_we, "R7 short inc/dec",
            wr_data, e);
    endtask

    task automatic t_ffid(input [2:0] sub, input [2:0] rm, input [31:0] v);
        logic [31:0] e;
        e = sub[0] ? v - 1 : v + 1;
        drive(8'hFF, {2'b11, sub, rm}, v, 0);
        settle();
        chk(wr_en && wr_idx == rm && wr_data == e && !sz_we && !of_we, "R8 rm inc/dec",
            wr_data, e);
    endtask

    task automatic t_fault(input [7:0] op, input [7:0] mr);
        drive(op, mr, 32'h55, 32'h66);
        settle();
        chk(fault && !wr_en && !hi_wr_en && !sz_we && !of_we, "R9 fault",
            {fault, wr_en, hi_wr_en, sz_we, of_we}, 5'b10000);
        @(negedge clk);
        chk(!fault && !busy, "R9 fault one pulse", fault, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failed++; total++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        #1 t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_not(32'h0F0F_00FF, 3'd3);
        t_not(32'hFFFF_FFFF, 3'd6);
        t_neg(32'd1);
        t_neg(32'd0);
        t_neg(32'hFFFF_FFF0);
        t_neg(32'h8000_0000);
        t_mul(32'd4, 32'd3);
        t_mul(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        t_mul(32'h0001_0000, 32'h0002_0000);
        t_short(8'h41, 32'h1F);
        t_short(8'h47, 32'hFFFF_FFFF);
        t_short(8'h49, 32'h1F);
        t_short(8'h4A, 32'h0);
        t_ffid(3'd0, 3'd0, 32'h20);
        t_ffid(3'd1, 3'd5, 32'h0);
        t_fault(8'hF7, 8'hC0);
        t_fault(8'hFF, 8'hD0);
        t_fault(8'hF7, 8'h13);
        t_fault(8'h01, 8'hD8);
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule